// File: doc/BRIEF.md
# Logic and Shift Execute Unit

This block is the logic-and-shift part of the execute stage of a 32-bit pipelined processor. Each cycle it takes an operation code, two 32-bit operands and the destination register write enable and address. It returns the 32-bit result, and it hands the write enable and address on unchanged to the next stage. It performs bitwise OR, AND, XOR and NOR. It also performs left shift, logical right shift and arithmetic right shift.

For shifts, operand A is the value to be shifted and operand B holds the shift amount. Only the five low bits of operand B count. Decode has already zero-extended any immediate before it reaches this block. The unit is a single combinational datapath followed by an optional output register. The register is on by default and gives a latency of one cycle.

Top module: `lsx_unit`

## Requirements
- R1: With op code 0x1 the result is the bitwise OR of operand A and operand B.
- R2: With op code 0x2 the result is the bitwise AND of the operands. For example, 0x01011101 AND 0x000000FE gives 0x00000000.
- R3: With op code 0x3 the result is the bitwise XOR of the operands.
- R4: With op code 0x4 the result is the inverse of (A OR B). For example, 0x0000FF00 with 0x0000FF00 gives 0xFFFF00FF.
- R5: With op code 0x5 the result is A shifted left, with zeros entering at bit 0. For example, 0x00001010 shifted by 19 gives 0x80800000.
- R6: With op code 0x6 the result is A shifted right, with zeros entering at bit 31. For example, 0x02020000 shifted by 8 gives 0x00020200.
- R7: With op code 0x7 the result is A shifted right, with copies of A's bit 31 entering at the top. For example, 0x80800000 shifted by 16 gives 0xFFFF8080.
- R8: The shift amount is operand B bits 4:0. Bits 31:5 of operand B have no effect on any shift, and an amount of 0 returns A unchanged.
- R9: Op codes 0x0 and 0x8 to 0xF give a result of zero.
- R10: The outputs wen_o and waddr_o equal wen_i and waddr_i for every op code, including unsupported ones.
- R11: With the output register on, the outputs appear one clock after the inputs. An active-low reset clears the result, wen_o and waddr_o to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | Operand A; the shifted value for shifts |
| opb_i | input | 32 | Operand B; the shift amount in bits 4:0 for shifts |
| wen_i | input | 1 | Destination write enable from decode |
| waddr_i | input | 5 | Destination register address from decode |
| res_o | output | 32 | Operation result |
| wen_o | output | 1 | Forwarded write enable |
| waddr_o | output | 5 | Forwarded destination address |

## Verification
The assertions assume that every input is known and stable around each rising clock edge. They also assume that reset is low from time zero. The bench meets both conditions: it drives all inputs only on falling edges, and it holds reset low for several cycles before the first operation. The shift assertions also assume that the op code and operand B of one cycle fully determine the next result. The bench therefore sends a new operation every cycle and never leaves a gap of stale inputs between them.

// File: rtl/lsx_unit.sv
module lsx_unit #(
  parameter int DW      = 32,
  parameter int AW      = 5,
  parameter int OPW     = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  opa_i,
  input  logic [DW-1:0]  opb_i,
  input  logic           wen_i,
  input  logic [AW-1:0]  waddr_i,
  output logic [DW-1:0]  res_o,
  output logic           wen_o,
  output logic [AW-1:0]  waddr_o
);

  localparam int SHW = $clog2(DW);

  localparam logic [OPW-1:0] OP_OR  = OPW'(1);
  localparam logic [OPW-1:0] OP_AND = OPW'(2);
  localparam logic [OPW-1:0] OP_XOR = OPW'(3);
  localparam logic [OPW-1:0] OP_NOR = OPW'(4);
  localparam logic [OPW-1:0] OP_SLL = OPW'(5);
  localparam logic [OPW-1:0] OP_SRL = OPW'(6);
  localparam logic [OPW-1:0] OP_SRA = OPW'(7);

  logic [SHW-1:0] shamt;
  logic [DW-1:0]  res_c;

  assign shamt = opb_i[SHW-1:0];

  always_comb begin
    unique case (op_i)
      OP_OR:   res_c = opa_i | opb_i;
      OP_AND:  res_c = opa_i & opb_i;
      OP_XOR:  res_c = opa_i ^ opb_i;
      OP_NOR:  res_c = ~(opa_i | opb_i);
      OP_SLL:  res_c = opa_i << shamt;
      OP_SRL:  res_c = opa_i >> shamt;
      OP_SRA:  res_c = DW'($signed(opa_i) >>> shamt);
      default: res_c = '0;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          res_o   <= '0;
          wen_o   <= 1'b0;
          waddr_o <= '0;
        end else begin
          res_o   <= res_c;
          wen_o   <= wen_i;
          waddr_o <= waddr_i;
        end
      end

      AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && !wen_o && waddr_o == '0)); // R11
      AST_DEST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (wen_o == $past(wen_i) && waddr_o == $past(waddr_i))); // R10
      AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == '0 || op_i > OP_SRA) |=> res_o == '0); // R9
      AST_SRA_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SRA && opa_i[DW-1]) |=> res_o[DW-1]); // R7
      AST_SRL_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SRL && opb_i[SHW-1:0] != '0) |=> !res_o[DW-1]); // R6
      AST_SLL_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SLL && opb_i[SHW-1:0] != '0) |=> !res_o[0]); // R5
      AST_ZERO_SHAMT: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_SLL || op_i == OP_SRL || op_i == OP_SRA) && opb_i[SHW-1:0] == '0)
        |=> res_o == $past(opa_i)); // R8
    end else begin : g_comb
      assign res_o   = res_c;
      assign wen_o   = wen_i;
      assign waddr_o = waddr_i;
    end
  endgenerate

endmodule

// File: tb/lsx_unit_test.sv
`timescale 1ns/1ps
module lsx_unit_test;

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [4:0]  wa;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = 4'h1;
  logic [31:0] opa_i = 32'hFFFF_FFFF;
  logic [31:0] opb_i = 32'h1234_5678;
  logic        wen_i = 1'b1;
  logic [4:0]  waddr_i = 5'd31;
  logic [31:0] res_o;
  logic        wen_o;
  logic [4:0]  waddr_o;

  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  lsx_unit uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
    .wen_i(wen_i), .waddr_i(waddr_i), .res_o(res_o), .wen_o(wen_o), .waddr_o(waddr_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic we, logic [4:0] wa, logic [31:0] exp_res, string req);
    exp_t e;
    @(negedge clk);
    op_i = op; opa_i = a; opb_i = b; wen_i = we; waddr_i = wa;
    e.res = exp_res; e.we = we; e.wa = wa; e.req = req;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.req, res_o, e.res);
        check("R10", {26'd0, wen_o, waddr_o}, {26'd0, e.we, e.wa});
      end
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset res", res_o, 32'h0);
    check("R11 reset wen", {31'd0, wen_o}, 32'h0);
    check("R11 reset waddr", {27'd0, waddr_o}, 32'h0);
    rst_n = 1'b1;

    drive(4'h1, 32'h0101_0000, 32'h0000_0101, 1'b1, 5'd1, 32'h0101_0101, "R1");
    drive(4'h1, 32'h0101_0101, 32'h0000_1100, 1'b1, 5'd2, 32'h0101_1101, "R1");
    drive(4'h1, 32'h0101_0101, 32'h0101_1101, 1'b1, 5'd1, 32'h0101_1101, "R1");
    drive(4'h2, 32'h0101_1101, 32'h0000_00FE, 1'b1, 5'd3, 32'h0000_0000, "R2");
    drive(4'h2, 32'hF0F0_FFFF, 32'hFF00_1234, 1'b0, 5'd9, 32'hF000_1234, "R2");
    drive(4'h3, 32'h0000_0000, 32'h0000_FF00, 1'b1, 5'd4, 32'h0000_FF00, "R3");
    drive(4'h3, 32'hAAAA_5555, 32'hFFFF_0000, 1'b1, 5'd1, 32'h5555_5555, "R3");
    drive(4'h4, 32'h0000_FF00, 32'h0000_FF00, 1'b1, 5'd1, 32'hFFFF_00FF, "R4");
    drive(4'h4, 32'h0000_0000, 32'h0000_0000, 1'b0, 5'd0, 32'hFFFF_FFFF, "R4");

    drive(4'h5, 32'h0404_0404, 32'd8, 1'b1, 5'd2, 32'h0404_0400, "R5");
    drive(4'h5, 32'h0404_0400, 32'd7, 1'b1, 5'd2, 32'h0202_0000, "R5");
    drive(4'h5, 32'h0000_1010, 32'd19, 1'b1, 5'd2, 32'h8080_0000, "R5");
    drive(4'h6, 32'h0202_0000, 32'd8, 1'b1, 5'd2, 32'h0002_0200, "R6");
    drive(4'h6, 32'h0002_0200, 32'd5, 1'b1, 5'd2, 32'h0000_1010, "R6");
    drive(4'h6, 32'h8000_0000, 32'd31, 1'b1, 5'd6, 32'h0000_0001, "R6");
    drive(4'h7, 32'h8080_0000, 32'd16, 1'b1, 5'd2, 32'hFFFF_8080, "R7");
    drive(4'h7, 32'hFFFF_8080, 32'd8, 1'b1, 5'd2, 32'hFFFF_FF80, "R7");
    drive(4'h7, 32'h4000_0000, 32'd4, 1'b1, 5'd2, 32'h0400_0000, "R7");
    drive(4'h7, 32'h8000_0000, 32'd31, 1'b1, 5'd2, 32'hFFFF_FFFF, "R7");

    drive(4'h6, 32'h0202_0000, 32'hFFFF_FF08, 1'b1, 5'd5, 32'h0002_0200, "R8");
    drive(4'h5, 32'h0000_1010, 32'h0000_0033, 1'b1, 5'd5, 32'h8080_0000, "R8");
    drive(4'h7, 32'h8080_0000, 32'h0000_0020, 1'b1, 5'd5, 32'h8080_0000, "R8");
    drive(4'h5, 32'h1234_5678, 32'hFFFF_FFE0, 1'b0, 5'd5, 32'h1234_5678, "R8");

    drive(4'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 5'd7, 32'h0, "R9");
    drive(4'h8, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 5'd30, 32'h0, "R9");
    drive(4'hF, 32'h1234_5678, 32'h8765_4321, 1'b0, 5'd17, 32'h0, "R9");

    @(negedge clk);
    op_i = 4'h0; wen_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 queue drained", q.size(), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    #20000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule